// File: doc/BRIEF.md
# Framestore Pixel Fetch and Expansion

This block reads a memory-mapped framestore one 32-bit word at a time and turns each word into 24-bit RGB pixels with a transparency flag. Pixels leave on a valid/ready stream, in raster order from the top-left of the frame to the bottom-right. Each pixel carries a start-of-frame marker and an end-of-row marker. The block issues at most one word read at a time on a simple request/ready port.

Software sets five things: a base word address, a row pitch in words, a visible row width in words, a row count and a depth code. Depths of 8 bits or fewer go through a 256-entry palette, which the host writes through a plain write port. The 16-bit and 32-bit depths are expanded straight from the pixel bits. The block samples the configuration pins only when a frame starts. While `run` is held high, frames follow one another back to back.

Back-pressure on the pixel stream works as follows. A pixel is consumed on a cycle where `pix_valid` and `pix_ready` are both high. While `pix_valid` is high and `pix_ready` is low, the pixel, its markers and its flag stay unchanged. `pix_valid` does not depend on `pix_ready`. A memory read is in flight while `mem_req` is high and completes on the cycle in which `mem_ready` is high, with `mem_rdata` valid in that same cycle.

Top module: `fb_pixel_fetch`

## Requirements
- R1: After reset, `mem_req` and `pix_valid` are both low.
- R2: The word for row r, column c is read at `base + r*pitch + c`. No word with c at or above the row width is ever read, so the padding between rows is never read.
- R3: Within a row, words are read in ascending column order, and rows are read in ascending order. Every pixel of every word is emitted, and a frame delivers exactly rows × width × (32/bpp) pixels.
- R4: The depth code selects bits per pixel as follows: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, 4 gives 16 and 5 gives 32. At 1, 2 and 4 bpp, pixel k of a word comes from bits [k*bpp +: bpp], so the leftmost pixel is in the least-significant bits.
- R5: At depths of 8 bpp or fewer, the pixel value indexes the palette. A palette entry holds blue in bits 31:24, green in 23:16, red in 15:8 and a supremacy byte in 7:0. The transparency flag is high when that byte is non-zero.
- R6: At 16 bpp, the low halfword is emitted first. Red is in bits 4:0, green in 9:5, blue in 14:10, and bit 15 is the transparency flag. Each 5-bit channel is widened to 8 bits as {c, c[4:2]}.
- R7: At 32 bpp, red is in bits 7:0, green in 15:8 and blue in 23:16. The transparency flag is high when bits 31:24 are non-zero.
- R8: `pix_sof` is high only on the first pixel of a frame. `pix_eol` is high only on the last pixel of each row.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and the pixel, markers and flag do not change.
- R10: At most one read is outstanding. `mem_req` holds with a stable address until `mem_ready`, and no read is requested while a pixel is waiting on the stream.
- R11: Configuration pin changes made during a frame have no effect on that frame.
- R12: While `run` is high, a new frame starts after each frame ends. After the last frame with `run` low, `mem_req` and `pix_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Start or repeat frames while high |
| cfg_base | input | ADDR_W | Word address of the first visible word |
| cfg_pitch | input | CNT_W | Words between row starts |
| cfg_width | input | CNT_W | Visible words per row (non-zero) |
| cfg_rows | input | CNT_W | Visible rows (non-zero) |
| cfg_depth | input | 3 | Depth code 0..5; codes 6 and 7 are treated as 5 |
| mem_req | output | 1 | Word read request |
| mem_addr | output | ADDR_W | Word address of the read |
| mem_ready | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 8 | Palette entry index |
| pal_wdata | input | 32 | Palette entry value |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Consumer accepts pixel |
| pix_r | output | 8 | Red |
| pix_g | output | 8 | Green |
| pix_b | output | 8 | Blue |
| pix_transp | output | 1 | Pixel is transparent |
| pix_sof | output | 1 | First pixel of a frame |
| pix_eol | output | 1 | Last pixel of a row |

## Verification
Some rules are checked by assertions on every cycle. These are the hold rules on the memory port and on the pixel stream, the exclusion between an open read and a pending pixel, the row-width bound on the column being fetched, and the frozen configuration while a frame is in progress.

The colour expansion, the sub-word pixel order, the palette layout, the address arithmetic with pitches wider than the row, and the marker placement can only be shown by the bench's scenarios. These compare each accepted pixel and each read address against values computed from the requirements. The scenarios also vary memory latency and consumer stalls.

// File: rtl/fbpf_pkg.sv
package fbpf_pkg;
  localparam int WORD_W = 32;
  localparam int CHAN_W = 8;

  typedef enum logic [2:0] {
    DEP_1  = 3'd0,
    DEP_2  = 3'd1,
    DEP_4  = 3'd2,
    DEP_8  = 3'd3,
    DEP_16 = 3'd4,
    DEP_32 = 3'd5
  } depth_e;

  typedef struct packed {
    logic [CHAN_W-1:0] r;
    logic [CHAN_W-1:0] g;
    logic [CHAN_W-1:0] b;
    logic              transp;
  } rgbt_t;

  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction
endpackage

// File: rtl/fbpf_palette.sv
module fbpf_palette #(
  parameter int IDX_W = 8,
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ENT_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) ent[wr_idx] <= wr_data;
  end

  // Asynchronous read: the looked-up colour is ready in the cycle the pixel is shown
  assign rd_data = ent[rd_idx];
endmodule

// File: rtl/fbpf_expand.sv
module fbpf_expand
  import fbpf_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  depth_e            depth,
  input  logic [WORD_W-1:0] raw,
  input  logic [WORD_W-1:0] pal_ent,
  output logic [IDX_W-1:0]  pal_idx,
  output rgbt_t             pix
);
  assign pal_idx = raw[IDX_W-1:0];

  always_comb begin
    pix = '0;
    unique case (depth)
      DEP_16: begin
        pix.r      = widen5(raw[4:0]);
        pix.g      = widen5(raw[9:5]);
        pix.b      = widen5(raw[14:10]);
        pix.transp = raw[15];
      end
      DEP_32: begin
        pix.r      = raw[7:0];
        pix.g      = raw[15:8];
        pix.b      = raw[23:16];
        pix.transp = |raw[31:24];
      end
      default: begin
        // Palette entry: blue on top, then green, red, supremacy byte at the bottom
        pix.r      = pal_ent[15:8];
        pix.g      = pal_ent[23:16];
        pix.b      = pal_ent[31:24];
        pix.transp = |pal_ent[7:0];
      end
    endcase
  end
endmodule

// File: rtl/fbpf_scan.sv
module fbpf_scan
  import fbpf_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [CNT_W-1:0]  cfg_pitch,
  input  logic [CNT_W-1:0]  cfg_width,
  input  logic [CNT_W-1:0]  cfg_rows,
  input  logic [2:0]        cfg_depth,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [WORD_W-1:0] raw_pix,
  output depth_e            depth_q,
  output logic              sof,
  output logic              eol
);
  localparam int IDX_W = $clog2(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EMIT} state_e;

  state_e            st;
  logic [ADDR_W-1:0] row_addr_q;
  logic [CNT_W-1:0]  pitch_q, width_q, rows_q;
  logic [CNT_W-1:0]  row_q, col_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] word_q;

  logic [IDX_W-1:0]  idx_last;
  logic [IDX_W-1:0]  shamt;
  logic [IDX_W:0]    bpp;
  logic [WORD_W-1:0] mask;
  logic              at_idx_end, at_col_end, at_row_end, cfg_ok;
  depth_e            depth_in;

  assign depth_in   = (cfg_depth > 3'd5) ? DEP_32 : depth_e'(cfg_depth);
  assign cfg_ok     = (cfg_rows != '0) && (cfg_width != '0);

  assign idx_last   = IDX_W'(WORD_W - 1) >> depth_q;
  assign bpp        = (IDX_W+1)'(1) << depth_q;
  assign shamt      = IDX_W'(idx_q << depth_q);
  assign mask       = (depth_q == DEP_32) ? '1 : ((WORD_W'(1) << bpp) - WORD_W'(1));
  assign raw_pix    = (word_q >> shamt) & mask;

  assign at_idx_end = (idx_q == idx_last);
  assign at_col_end = (col_q == width_q - CNT_W'(1));
  assign at_row_end = (row_q == rows_q - CNT_W'(1));

  assign mem_req    = (st == S_FETCH);
  assign mem_addr   = row_addr_q + ADDR_W'(col_q);
  assign pix_valid  = (st == S_EMIT);
  assign sof        = (row_q == '0) && (col_q == '0) && (idx_q == '0);
  assign eol        = at_col_end && at_idx_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      row_addr_q <= '0;
      pitch_q    <= '0;
      width_q    <= '0;
      rows_q     <= '0;
      depth_q    <= DEP_1;
      row_q      <= '0;
      col_q      <= '0;
      idx_q      <= '0;
      word_q     <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (run && cfg_ok) begin
            row_addr_q <= cfg_base;
            pitch_q    <= cfg_pitch;
            width_q    <= cfg_width;
            rows_q     <= cfg_rows;
            depth_q    <= depth_in;
            row_q      <= '0;
            col_q      <= '0;
            idx_q      <= '0;
            st         <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ready) begin
            word_q <= mem_rdata;
            idx_q  <= '0;
            st     <= S_EMIT;
          end
        end
        S_EMIT: begin
          if (pix_ready) begin
            if (!at_idx_end) begin
              idx_q <= idx_q + IDX_W'(1);
            end else if (!at_col_end) begin
              col_q <= col_q + CNT_W'(1);
              st    <= S_FETCH;
            end else if (!at_row_end) begin
              row_q      <= row_q + CNT_W'(1);
              col_q      <= '0;
              row_addr_q <= row_addr_q + ADDR_W'(pitch_q);
              st         <= S_FETCH;
            end else begin
              row_q <= '0;
              col_q <= '0;
              idx_q <= '0;
              st    <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)))
    else $error("read request dropped or moved"); // R10

  AST_SINGLE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && pix_valid))
    else $error("read open while a pixel waits"); // R10

  AST_PIX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(raw_pix) && $stable(sof) && $stable(eol)))
    else $error("stalled pixel changed"); // R9

  AST_NO_PAD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (col_q < width_q))
    else $error("padding word fetched"); // R2

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |->
      ($stable(depth_q) && $stable(pitch_q) && $stable(width_q) && $stable(rows_q)))
    else $error("frame configuration changed mid-frame"); // R11
endmodule

// File: rtl/fb_pixel_fetch.sv
module fb_pixel_fetch
  import fbpf_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 12,
  parameter int PAL_IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic [CNT_W-1:0]     cfg_pitch,
  input  logic [CNT_W-1:0]     cfg_width,
  input  logic [CNT_W-1:0]     cfg_rows,
  input  logic [2:0]           cfg_depth,
  output logic                 mem_req,
  output logic [ADDR_W-1:0]    mem_addr,
  input  logic                 mem_ready,
  input  logic [31:0]          mem_rdata,
  input  logic                 pal_we,
  input  logic [PAL_IDX_W-1:0] pal_addr,
  input  logic [31:0]          pal_wdata,
  output logic                 pix_valid,
  input  logic                 pix_ready,
  output logic [7:0]           pix_r,
  output logic [7:0]           pix_g,
  output logic [7:0]           pix_b,
  output logic                 pix_transp,
  output logic                 pix_sof,
  output logic                 pix_eol
);
  logic [WORD_W-1:0]    raw_pix;
  logic [WORD_W-1:0]    pal_ent;
  logic [PAL_IDX_W-1:0] pal_idx;
  depth_e               depth_q;
  rgbt_t                pix;

  fbpf_scan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cfg_base  (cfg_base),
    .cfg_pitch (cfg_pitch),
    .cfg_width (cfg_width),
    .cfg_rows  (cfg_rows),
    .cfg_depth (cfg_depth),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .raw_pix   (raw_pix),
    .depth_q   (depth_q),
    .sof       (pix_sof),
    .eol       (pix_eol)
  );

  fbpf_palette #(.IDX_W(PAL_IDX_W), .ENT_W(WORD_W)) u_pal (
    .clk     (clk),
    .wr_en   (pal_we),
    .wr_idx  (pal_addr),
    .wr_data (pal_wdata),
    .rd_idx  (pal_idx),
    .rd_data (pal_ent)
  );

  fbpf_expand #(.IDX_W(PAL_IDX_W)) u_exp (
    .depth   (depth_q),
    .raw     (raw_pix),
    .pal_ent (pal_ent),
    .pal_idx (pal_idx),
    .pix     (pix)
  );

  assign pix_r      = pix.r;
  assign pix_g      = pix.g;
  assign pix_b      = pix.b;
  assign pix_transp = pix.transp;
endmodule

// File: tb/sim_fb_pixel_fetch.sv
module sim_fb_pixel_fetch;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [CNT_W-1:0]  cfg_pitch = '0, cfg_width = '0, cfg_rows = '0;
  logic [2:0]        cfg_depth = '0;
  logic              mem_req, mem_ready = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata = '0;
  logic              pal_we = 1'b0;
  logic [7:0]        pal_addr = '0;
  logic [31:0]       pal_wdata = '0;
  logic              pix_valid, pix_ready = 1'b0;
  logic [7:0]        pix_r, pix_g, pix_b;
  logic              pix_transp, pix_sof, pix_eol;

  always #10 clk = ~clk;

  fb_pixel_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u0 (.*);

  int tests = 0, fails = 0;
  int a_base, a_pitch, a_width, a_rows, a_depth;
  int m_row, m_col, p_row, p_word, p_idx;
  int pix_count, sof_seen, wait_c, bp_cnt;
  bit mem_slow, bp_mode;
  bit hold_pend, mreq_pend;
  logic [27:0] hold_val;
  logic [ADDR_W-1:0] mreq_addr;

  function automatic logic [31:0] memfn(input int a);
    logic [31:0] x;
    x = 32'(a) * 32'h9E3779B1;
    return x ^ 32'h13579BDF;
  endfunction

  function automatic logic [31:0] palfn(input int i);
    logic [7:0] v;
    v = 8'(i);
    return {v ^ 8'hFF, 8'(i * 7), v + 8'h11, ((i % 5) == 0) ? 8'h80 : 8'h00};
  endfunction

  // Expected {r,g,b,transp} from the requirement text
  function automatic logic [24:0] exp_pix(input int d, input logic [31:0] w, input int k);
    int bpp;
    logic [31:0] raw, msk, p;
    logic [4:0] r5, g5, b5;
    bpp = 1 << d;
    msk = (bpp == 32) ? 32'hFFFF_FFFF : ((32'h1 << bpp) - 32'h1);
    raw = (w >> (k * bpp)) & msk;
    if (d <= 3) begin
      p = palfn(int'(raw[7:0]));
      return {p[15:8], p[23:16], p[31:24], p[7:0] != 8'h00};
    end else if (d == 4) begin
      r5 = raw[4:0]; g5 = raw[9:5]; b5 = raw[14:10];
      return {r5, r5[4:2], g5, g5[4:2], b5, b5[4:2], raw[15]};
    end
    return {raw[7:0], raw[15:8], raw[23:16], raw[31:24] != 8'h00};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge, then judge what the next rising edge will see
  always @(negedge clk) begin
    bp_cnt++;
    if (rst_n) begin
      if (hold_pend)
        check(pix_valid && ({pix_r, pix_g, pix_b, pix_transp, pix_sof, pix_eol} == {1'b0, hold_val[26:0]}),
              "R9", "stalled pixel", 32'({pix_r, pix_g, pix_b, pix_transp}), 32'(hold_val[26:2]));
      if (mreq_pend)
        check(mem_req && mem_addr == mreq_addr, "R10", "request hold",
              32'(mem_addr), 32'(mreq_addr));
      if (mem_req && pix_valid)
        check(1'b0, "R10", "read open with pixel pending", 32'd1, 32'd0);

      mem_ready = 1'b0;
      if (mem_req) begin
        if (!mem_slow || wait_c >= 2) begin
          mem_ready = 1'b1;
          wait_c = 0;
        end else wait_c++;
        mem_rdata = memfn(int'(mem_addr));
      end
      pix_ready = !bp_mode || (bp_cnt % 3 != 0);

      if (mem_req && mem_ready) begin
        logic [31:0] ea;
        ea = 32'(a_base + m_row * a_pitch + m_col);
        check(32'(mem_addr) == ea, "R2", "read address", 32'(mem_addr), ea);
        if (m_col == a_width - 1) begin
          m_col = 0;
          m_row = (m_row == a_rows - 1) ? 0 : m_row + 1;
        end else m_col++;
      end
      if (pix_valid && pix_ready) begin
        logic [24:0] e;
        logic [31:0] w;
        bit es, ee;
        int ppw;
        ppw = 32 >> a_depth;
        w = memfn(a_base + p_row * a_pitch + p_word);
        e = exp_pix(a_depth, w, p_idx);
        if (a_depth <= 2)
          check({pix_r, pix_g, pix_b, pix_transp} == e, "R4/R5", "packed pixel",
                32'({pix_r, pix_g, pix_b, pix_transp}), 32'(e));
        else if (a_depth == 3)
          check({pix_r, pix_g, pix_b, pix_transp} == e, "R5", "palette pixel",
                32'({pix_r, pix_g, pix_b, pix_transp}), 32'(e));
        else if (a_depth == 4)
          check({pix_r, pix_g, pix_b, pix_transp} == e, "R6", "16bpp pixel",
                32'({pix_r, pix_g, pix_b, pix_transp}), 32'(e));
        else
          check({pix_r, pix_g, pix_b, pix_transp} == e, "R7", "32bpp pixel",
                32'({pix_r, pix_g, pix_b, pix_transp}), 32'(e));
        es = (p_row == 0 && p_word == 0 && p_idx == 0);
        ee = (p_word == a_width - 1 && p_idx == ppw - 1);
        check(pix_sof == es && pix_eol == ee, "R8", "markers",
              32'({pix_sof, pix_eol}), 32'({es, ee}));
        if (pix_sof) sof_seen++;
        pix_count++;
        if (p_idx == ppw - 1) begin
          p_idx = 0;
          if (p_word == a_width - 1) begin
            p_word = 0;
            p_row = (p_row == a_rows - 1) ? 0 : p_row + 1;
          end else p_word++;
        end else p_idx++;
      end

      hold_pend = pix_valid && !pix_ready;
      hold_val  = {1'b0, pix_r, pix_g, pix_b, pix_transp, pix_sof, pix_eol};
      mreq_pend = mem_req && !mem_ready;
      mreq_addr = mem_addr;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!mem_req && !pix_valid, "R1", "outputs in reset", 32'({mem_req, pix_valid}), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!mem_req && !pix_valid, "R1", "outputs after reset", 32'({mem_req, pix_valid}), 32'd0);
  endtask

  task automatic load_palette();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'(i); pal_wdata = palfn(i);
    end
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  task automatic t_frames(input int nfr, input int base, input int pitch, input int width,
                          input int rows, input int depth, input bit slow, input bit bp,
                          input bit disturb);
    int total, guard;
    bit idle_ok;
    @(negedge clk);
    a_base = base; a_pitch = pitch; a_width = width; a_rows = rows; a_depth = depth;
    cfg_base = ADDR_W'(base); cfg_pitch = CNT_W'(pitch); cfg_width = CNT_W'(width);
    cfg_rows = CNT_W'(rows); cfg_depth = 3'(depth);
    m_row = 0; m_col = 0; p_row = 0; p_word = 0; p_idx = 0;
    pix_count = 0; sof_seen = 0; mem_slow = slow; bp_mode = bp;
    total = rows * width * (32 >> depth);
    run = 1'b1;
    guard = 0;
    while (pix_count < (nfr - 1) * total + 1 && guard < 40000) begin
      @(negedge clk); guard++;
    end
    run = 1'b0;
    if (disturb) begin
      // R11: scramble every configuration pin while the frame is in flight
      cfg_base = ADDR_W'(base + 77); cfg_pitch = CNT_W'(pitch + 3);
      cfg_width = CNT_W'(width + 1); cfg_rows = CNT_W'(rows + 2);
      cfg_depth = 3'(5 - depth);
    end
    while (pix_count < nfr * total && guard < 40000) begin
      @(negedge clk); guard++;
    end
    check(pix_count == nfr * total, "R3", "pixel count", 32'(pix_count), 32'(nfr * total));
    check(sof_seen == nfr, "R12", "frames started", 32'(sof_seen), 32'(nfr));
    idle_ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (mem_req || pix_valid) idle_ok = 1'b0;
    end
    check(idle_ok, "R12", "idle after run drops", 32'(idle_ok), 32'd1);
    check(pix_count == nfr * total, "R11", "no extra pixels", 32'(pix_count), 32'(nfr * total));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R3): run did not complete, actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    load_palette();
    t_frames(1, 100, 5, 2, 3, 0, 1'b0, 1'b0, 1'b0);  // R4 1bpp, R2 wide pitch
    t_frames(1, 2000, 4, 2, 2, 1, 1'b1, 1'b1, 1'b0); // R4 2bpp, R9 R10 stalls
    t_frames(1, 37, 3, 3, 2, 2, 1'b0, 1'b1, 1'b0);   // R4 4bpp, pitch equals width
    t_frames(1, 500, 7, 4, 4, 3, 1'b1, 1'b1, 1'b0);  // R5 8bpp
    t_frames(1, 900, 6, 3, 2, 4, 1'b1, 1'b0, 1'b0);  // R6 16bpp
    t_frames(1, 4096, 9, 5, 3, 5, 1'b1, 1'b1, 1'b0); // R7 32bpp
    t_frames(1, 321, 5, 2, 3, 3, 1'b0, 1'b0, 1'b1);  // R11 mid-frame pin changes
    t_frames(2, 64, 4, 2, 2, 4, 1'b0, 1'b1, 1'b0);   // R12 back-to-back frames
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule